// File: doc/BRIEF.md
# Threshold-Flagged Byte FIFO

This block is the byte-wide staging buffer between the register or DMA side of a serial flash controller and its shift engine. It changes role with the transfer direction. In write mode the host pushes bytes and the engine drains them. In read mode the engine pushes bytes and the host drains them. The block always reports its fill level. It also raises a threshold flag, whose meaning depends on the direction. In write mode the flag says there is room for a programmed number of bytes. In read mode it says that many bytes are waiting, or that the transfer has finished and data remains.

The flag goes out as a DMA request when DMA is enabled. It goes out as a level interrupt when the interrupt enable is set. Host accesses are single bytes. A host write to a full FIFO is held off through `host_wr_ready`, and a host read from an empty FIFO is held off through `host_rd_valid`. The stored data is never overwritten or read twice.

Fill tracking is a three-state machine with the states ST_EMPTY, ST_PART and ST_FULL:
- ST_EMPTY goes to ST_PART on any accepted push.
- ST_PART goes to ST_FULL when a push is accepted without a pop while the level is one below the depth.
- ST_PART goes to ST_EMPTY when a pop is accepted without a push while the level is one.
- ST_FULL goes to ST_PART on any accepted pop.
- Every other case holds the current state.

Top module: `byte_thr_fifo`

## Requirements
- R1: After reset the level is 0, `host_wr_ready` is 1 in write mode (`dir_read`=0) and `host_rd_valid` is 0.
- R2: Bytes leave in the order they entered. `level` rises by one per accepted push and falls by one per accepted pop, never exceeding DEPTH (32).
- R3: In write mode `thr_flag` is 1 exactly when DEPTH − level ≥ `thr_m1`+1.
- R4: In read mode (`dir_read`=1) `thr_flag` is 1 exactly when level ≥ `thr_m1`+1, or when `xfer_done`=1 and level > 0.
- R5: `dma_req` equals `thr_flag` AND `dma_en`.
- R6: `irq` equals `thr_flag` AND `thr_ie`.
- R7: When the FIFO is full, the producer is held off (`host_wr_ready`=0 in write mode), the attempted push is dropped, the level stays 32 and the stored data is unchanged.
- R8: When the FIFO is empty, the consumer sees no data (`host_rd_valid`=0 in read mode), and a pop attempt leaves the level at 0.
- R9: The producer port belonging to the other direction has no effect. A host write in read mode and an engine push in write mode leave the level unchanged.
- R10: A push and a pop accepted in the same cycle leave the level unchanged and keep the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_read | input | 1 | 1: engine fills and host drains; 0: host fills and engine drains |
| xfer_done | input | 1 | Engine has finished the read transfer |
| thr_m1 | input | 5 | Threshold minus one (0 means 1 byte, 31 means 32 bytes) |
| dma_en | input | 1 | Forward the flag as a DMA request |
| thr_ie | input | 1 | Forward the flag as an interrupt |
| host_wr_en | input | 1 | Host byte write request |
| host_wr_data | input | 8 | Host write byte |
| host_wr_ready | output | 1 | Host write accepted this cycle if requested |
| host_rd_en | input | 1 | Host byte read request |
| host_rd_data | output | 8 | Byte at the head of the FIFO |
| host_rd_valid | output | 1 | Host read has data this cycle |
| eng_push | input | 1 | Engine stores a received byte |
| eng_push_data | input | 8 | Engine byte to store |
| eng_pop | input | 1 | Engine takes a byte to transmit |
| eng_rd_data | output | 8 | Byte at the head of the FIFO for the engine |
| level | output | 6 | Number of stored bytes, 0 to 32 |
| thr_flag | output | 1 | Threshold flag |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Threshold interrupt |

## Verification
The assertions assume that `dir_read` changes only while the FIFO is empty, so one direction's bytes never mix with the other's. The stimulus drains the FIFO completely before each direction change. The assertions also assume that requests are sampled only on clock edges. The stimulus therefore drives every request from the falling edge. The full threshold range is swept at every fill level in both directions, with and without `xfer_done`. This is possible because the flag depends on the threshold combinationally and needs no clock edge.

// File: rtl/tf_pkg.sv
package tf_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } fill_st_t;
endpackage

// File: rtl/tf_store.sv
module tf_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_ok,
    output logic [DW-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/tf_fill_ctrl.sv
module tf_fill_ctrl
    import tf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [LW-1:0] level,
    output logic          is_empty,
    output logic          is_full
);
    localparam logic [LW-1:0] LV_TOP = LW'(DEPTH - 1);
    localparam logic [LW-1:0] LV_ONE = LW'(1);

    fill_st_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                level <= '0;
        else if (push_ok && !pop_ok) level <= level + 1'b1;
        else if (pop_ok && !push_ok) level <= level - 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_EMPTY: if (push_ok) nxt = ST_PART;
            ST_PART: begin
                if (push_ok && !pop_ok && level == LV_TOP)      nxt = ST_FULL;
                else if (pop_ok && !push_ok && level == LV_ONE) nxt = ST_EMPTY;
            end
            ST_FULL:  if (pop_ok) nxt = ST_PART;
            default:  nxt = ST_EMPTY;
        endcase
    end

    always_comb begin
        is_empty = (state == ST_EMPTY);
        is_full  = (state == ST_FULL);
        push_ok  = push_req && !is_full;
        pop_ok   = pop_req && !is_empty;
    end
endmodule

// File: rtl/tf_thresh.sv
module tf_thresh #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic          dir_read,
    input  logic          xfer_done,
    input  logic [TW-1:0] thr_m1,
    input  logic [LW-1:0] level,
    input  logic          dma_en,
    input  logic          thr_ie,
    output logic          thr_flag,
    output logic          dma_req,
    output logic          irq
);
    logic [LW-1:0] thr;
    logic [LW-1:0] free_cnt;
    logic          room_ok;
    logic          data_ok;

    always_comb begin
        thr      = LW'(thr_m1) + LW'(1);
        free_cnt = LW'(DEPTH) - level;
        room_ok  = (free_cnt >= thr);
        data_ok  = (level >= thr) || (xfer_done && level != '0);
        thr_flag = dir_read ? data_ok : room_ok;
        dma_req  = thr_flag && dma_en;
        irq      = thr_flag && thr_ie;
    end
endmodule

// File: rtl/byte_thr_fifo.sv
module byte_thr_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_read,
    input  logic          xfer_done,
    input  logic [TW-1:0] thr_m1,
    input  logic          dma_en,
    input  logic          thr_ie,
    input  logic          host_wr_en,
    input  logic [DW-1:0] host_wr_data,
    output logic          host_wr_ready,
    input  logic          host_rd_en,
    output logic [DW-1:0] host_rd_data,
    output logic          host_rd_valid,
    input  logic          eng_push,
    input  logic [DW-1:0] eng_push_data,
    input  logic          eng_pop,
    output logic [DW-1:0] eng_rd_data,
    output logic [LW-1:0] level,
    output logic          thr_flag,
    output logic          dma_req,
    output logic          irq
);
    logic          push_req, pop_req, push_ok, pop_ok;
    logic          is_empty, is_full;
    logic [DW-1:0] push_data, head;

    always_comb begin
        push_req  = dir_read ? eng_push      : host_wr_en;
        push_data = dir_read ? eng_push_data : host_wr_data;
        pop_req   = dir_read ? host_rd_en    : eng_pop;
    end

    tf_fill_ctrl #(.DEPTH(DEPTH), .LW(LW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .pop_req(pop_req),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .level(level), .is_empty(is_empty), .is_full(is_full)
    );

    tf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_ok(push_ok), .wr_data(push_data),
        .rd_ok(pop_ok), .rd_data(head)
    );

    tf_thresh #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_thr (
        .dir_read(dir_read), .xfer_done(xfer_done), .thr_m1(thr_m1),
        .level(level), .dma_en(dma_en), .thr_ie(thr_ie),
        .thr_flag(thr_flag), .dma_req(dma_req), .irq(irq)
    );

    always_comb begin
        host_wr_ready = !dir_read && !is_full;
        host_rd_valid = dir_read && !is_empty;
        host_rd_data  = head;
        eng_rd_data   = head;
    end
endmodule

// File: rtl/tf_checker.sv
module tf_checker #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_read,
    input logic          host_wr_en,
    input logic          host_rd_en,
    input logic          eng_push,
    input logic          eng_pop,
    input logic          host_wr_ready,
    input logic          host_rd_valid,
    input logic          dma_en,
    input logic          thr_ie,
    input logic          thr_flag,
    input logic          dma_req,
    input logic          irq,
    input logic [LW-1:0] level
);
    logic prod, cons;
    assign prod = dir_read ? eng_push : host_wr_en;
    assign cons = dir_read ? host_rd_en : eng_pop;

    p_level_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + 1'b1) ||
        (level + 1'b1 == $past(level)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && !cons) |=> level == LW'(DEPTH));

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && !prod) |=> level == '0);

    p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_ready |-> (level < LW'(DEPTH) && !dir_read));

    p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_valid |-> (level != '0 && dir_read));

    p_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (dma_en && thr_flag));

    p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (thr_ie && thr_flag));
endmodule

bind byte_thr_fifo tf_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dir_read(dir_read),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .eng_push(eng_push), .eng_pop(eng_pop),
    .host_wr_ready(host_wr_ready), .host_rd_valid(host_rd_valid),
    .dma_en(dma_en), .thr_ie(thr_ie), .thr_flag(thr_flag),
    .dma_req(dma_req), .irq(irq), .level(level)
);

// File: tb/sim_byte_thr_fifo.sv
module sim_byte_thr_fifo;
    localparam int D = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_read = 1'b0, xfer_done = 1'b0, dma_en = 1'b0, thr_ie = 1'b0;
    logic [4:0] thr_m1 = '0;
    logic       host_wr_en = 1'b0, host_rd_en = 1'b0, eng_push = 1'b0, eng_pop = 1'b0;
    logic [7:0] host_wr_data = '0, eng_push_data = '0;
    logic       host_wr_ready, host_rd_valid, thr_flag, dma_req, irq;
    logic [7:0] host_rd_data, eng_rd_data;
    logic [5:0] level;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    byte_thr_fifo u0 (
        .clk(clk), .rst_n(rst_n), .dir_read(dir_read), .xfer_done(xfer_done),
        .thr_m1(thr_m1), .dma_en(dma_en), .thr_ie(thr_ie),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_wr_ready(host_wr_ready),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid),
        .eng_push(eng_push), .eng_push_data(eng_push_data), .eng_pop(eng_pop),
        .eng_rd_data(eng_rd_data), .level(level), .thr_flag(thr_flag),
        .dma_req(dma_req), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); host_wr_en = 1'b1; host_wr_data = d;
        @(negedge clk); host_wr_en = 1'b0;
    endtask

    task automatic eng_write(input logic [7:0] d);
        @(negedge clk); eng_push = 1'b1; eng_push_data = d;
        @(negedge clk); eng_push = 1'b0;
    endtask

    task automatic eng_take(output logic [7:0] d);
        @(negedge clk); d = eng_rd_data; eng_pop = 1'b1;
        @(negedge clk); eng_pop = 1'b0;
    endtask

    task automatic host_take(output logic [7:0] d);
        @(negedge clk); d = host_rd_data; host_rd_en = 1'b1;
        @(negedge clk); host_rd_en = 1'b0;
    endtask

    // Sweep every threshold at the current level; flag is combinational in thr_m1.
    task automatic sweep(input int lvl, input bit rd, input bit done);
        xfer_done = done;
        for (int t = 1; t <= D; t++) begin
            bit e;
            thr_m1 = 5'(t - 1);
            dma_en = t[0];
            thr_ie = t[1];
            #1;
            e = rd ? ((lvl >= t) || (done && lvl > 0)) : ((D - lvl) >= t);
            if (rd) chk(thr_flag == e, "R4 flag", int'(thr_flag), int'(e));
            else    chk(thr_flag == e, "R3 flag", int'(thr_flag), int'(e));
            chk(dma_req == (e && dma_en), "R5 dma_req", int'(dma_req), int'(e && dma_en));
            chk(irq == (e && thr_ie), "R6 irq", int'(irq), int'(e && thr_ie));
        end
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(level == 0, "R1 level", int'(level), 0);
        chk(host_wr_ready == 1'b1, "R1 wr_ready", int'(host_wr_ready), 1);
        chk(host_rd_valid == 1'b0, "R1 rd_valid", int'(host_rd_valid), 0);

        // Write mode: fill with sweeps at each level (R2, R3, R5, R6)
        for (int l = 0; l < D; l++) begin
            sweep(l, 1'b0, 1'b0);
            host_write(8'(l * 7 + 3));
            chk(level == 6'(l + 1), "R2 level up", int'(level), l + 1);
            if (l == 5) begin
                eng_write(8'hEE); // R9 engine push ignored in write mode
                chk(level == 6'(6), "R9 eng push ignored", int'(level), 6);
            end
        end
        sweep(D, 1'b0, 1'b0);
        // R7 full: stall and drop
        chk(host_wr_ready == 1'b0, "R7 wr_ready at full", int'(host_wr_ready), 0);
        host_write(8'hFF);
        chk(level == 6'(D), "R7 level stays full", int'(level), D);
        // Drain by engine: order (R2) and data untouched by the dropped write (R7)
        for (int l = 0; l < D; l++) begin
            eng_take(d);
            chk(d == 8'(l * 7 + 3), "R2 R7 order", int'(d), (l * 7 + 3) & 255);
            chk(level == 6'(D - 1 - l), "R2 level down", int'(level), D - 1 - l);
        end
        // R8 empty pop attempt
        eng_take(d);
        chk(level == 0, "R8 level stays empty", int'(level), 0);

        // R10 simultaneous push and pop
        host_write(8'h11); host_write(8'h22); host_write(8'h33);
        @(negedge clk);
        d = eng_rd_data;
        host_wr_en = 1'b1; host_wr_data = 8'h44; eng_pop = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; eng_pop = 1'b0;
        chk(d == 8'h11, "R10 head", int'(d), 8'h11);
        chk(level == 6'd3, "R10 level", int'(level), 3);
        for (int k = 0; k < 3; k++) begin
            eng_take(d);
            chk(d == 8'(8'h22 + 8'h11 * k), "R10 order", int'(d), int'(8'(8'h22 + 8'h11 * k)));
        end

        // Read mode
        dir_read = 1'b1;
        @(negedge clk);
        chk(host_rd_valid == 1'b0, "R8 rd_valid empty", int'(host_rd_valid), 0);
        host_take(d);
        chk(level == 0, "R8 empty read", int'(level), 0);
        for (int l = 0; l < D; l++) begin
            sweep(l, 1'b1, 1'b0);
            sweep(l, 1'b1, 1'b1);
            eng_write(8'(l ^ 8'hA5));
            if (l == 9) begin
                host_write(8'h00); // R9 host write ignored in read mode
                chk(level == 6'(10), "R9 host write ignored", int'(level), 10);
            end
        end
        sweep(D, 1'b1, 1'b0);
        sweep(D, 1'b1, 1'b1);
        eng_write(8'h77);
        chk(level == 6'(D), "R7 read-mode full", int'(level), D);
        for (int l = 0; l < D; l++) begin
            chk(host_rd_valid == 1'b1, "R2 rd_valid", int'(host_rd_valid), 1);
            host_take(d);
            chk(d == 8'(l ^ 8'hA5), "R2 read order", int'(d), l ^ 8'hA5);
        end
        chk(level == 0, "R2 drained", int'(level), 0);
        chk(host_rd_valid == 1'b0, "R8 rd_valid after drain", int'(host_rd_valid), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule